// File: doc/BRIEF.md
# LCD Multiplexed Frame Timing Generator

This block produces the common-plane timing for a multiplexed segment LCD. A tick enable sets the common-slot rate. Each slot lasts `SLOT_TICKS` ticks. A frame holds two half-frames of opposite polarity, and each half-frame holds one slot for every active common line. For each of the four common lines the block drives a 2-bit level code, and an external resistor ladder or switch array turns each code into a voltage.

Pixel data for the next frame is read during a short burst near the end of each frame. The burst has one tick per active common, and the block shows it on a fetch indicator together with a slot index. Right after the last fetch, a sticky interrupt flag is set. This happens `WIN = SLOT_TICKS + MARGIN_TICKS` ticks before the next frame boundary. Software can then rewrite segment data safely before the controller reads it again. A one-cycle strobe marks each frame start.

Top module: `lcd_frame_timer`

## Requirements
- R1: The number of active commons is `mux_i + 1`. Within each half-frame the selected common steps from COM0 up to the last active common, one slot of `SLOT_TICKS` ticks each.
- R2: Level codes are 3 = full supply, 2 = two thirds, 1 = one third, 0 = ground. COM i occupies `com_lvl_o[2i+1:2i]`. In the first half-frame the selected common is 3 and all other commons (inactive ones included) are 1. In the second half-frame the selected common is 0 and the others are 2.
- R3: `frame_start_o` is high for exactly one cycle after the tick that wraps the frame. At that point COM0 is selected in the first half-frame.
- R4: With frame length F = 2·N·SLOT_TICKS ticks, the frame position is counted from 0. `fetch_o` is high for positions F−WIN−N to F−WIN−1. While it is high, `fetch_slot_o` counts 0 to N−1; otherwise `fetch_slot_o` is 0.
- R5: The interrupt flag is set on the tick that ends the last fetch, so it rises when the position reaches F−WIN, which is WIN ticks before the frame boundary.
- R6: `irq_o` stays high until `irq_clr_i` is sampled high. If a set and a clear fall in the same cycle, the flag stays high.
- R7: A new `mux_i` value is taken only on the frame-wrapping tick. Changes made in the middle of a frame do not alter the current frame.
- R8: Asynchronous reset clears the position, the flag and the strobe, and selects quarter duty. The commons then show code 3 on COM0 and code 1 on the others.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Timing tick enable |
| mux_i | input | 2 | Active commons minus one |
| irq_clr_i | input | 1 | Clear pulse for the interrupt flag |
| com_lvl_o | output | 8 | Level code for each common line, 2 bits each |
| frame_start_o | output | 1 | One-cycle frame-start strobe |
| fetch_o | output | 1 | Pixel fetch in progress |
| fetch_slot_o | output | 2 | Slot whose pixels are being fetched |
| irq_o | output | 1 | Sticky frame interrupt flag |

## Verification
Ticks arrive both back to back and with random gaps. The back-to-back runs cover the position arithmetic at full rate, and the gapped runs show that every counter holds while the tick is low. Random changes to the multiplex field, made in the middle of a frame and checked against a reference model, separate a latch taken at the frame boundary from immediate use of the new value. Every one of the four duty settings is also visited. A directed clear that lands exactly on the set cycle shows whether the set wins. A later clear with no set pending confirms that the flag can be cleared.

// File: rtl/lcd_frame_pkg.sv
package lcd_frame_pkg;
  localparam int NCOM = 4;

  typedef enum logic [1:0] {
    LVL_GND  = 2'd0,
    LVL_ONE  = 2'd1,
    LVL_TWO  = 2'd2,
    LVL_FULL = 2'd3
  } lvl_e;
endpackage

// File: rtl/lcd_frame_timebase.sv
module lcd_frame_timebase #(
  parameter int SLOT_TICKS = 4,
  parameter int PW = 6
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tick_i,
  input  logic [1:0]    mux_i,
  output logic [1:0]    act_mux_o,
  output logic [1:0]    slot_o,
  output logic          half_o,
  output logic [PW-1:0] pos_o,
  output logic [PW-1:0] frame_len_o,
  output logic          frame_start_o
);
  localparam int TW = (SLOT_TICKS > 1) ? $clog2(SLOT_TICKS) : 1;

  logic [TW-1:0] sub_q;
  logic [1:0]    slot_q, mux_q;
  logic          half_q, fs_q;
  logic [PW-1:0] pos_q;
  logic          sub_end, slot_end, wrap;

  assign sub_end  = (sub_q == TW'(SLOT_TICKS - 1));
  assign slot_end = (slot_q == mux_q);
  assign wrap     = tick_i && sub_end && slot_end && half_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sub_q  <= '0;
      slot_q <= '0;
      half_q <= 1'b0;
      pos_q  <= '0;
      mux_q  <= 2'd3;
      fs_q   <= 1'b0;
    end else begin
      fs_q <= wrap;
      if (tick_i) begin
        if (wrap) begin
          sub_q  <= '0;
          slot_q <= '0;
          half_q <= 1'b0;
          pos_q  <= '0;
          mux_q  <= mux_i;
        end else begin
          pos_q <= pos_q + 1'b1;
          if (sub_end) begin
            sub_q <= '0;
            if (slot_end) begin
              slot_q <= '0;
              half_q <= 1'b1;
            end else begin
              slot_q <= slot_q + 1'b1;
            end
          end else begin
            sub_q <= sub_q + 1'b1;
          end
        end
      end
    end
  end

  assign act_mux_o     = mux_q;
  assign slot_o        = slot_q;
  assign half_o        = half_q;
  assign pos_o         = pos_q;
  assign frame_len_o   = PW'(2 * SLOT_TICKS * (int'(mux_q) + 1));
  assign frame_start_o = fs_q;
endmodule

// File: rtl/lcd_frame_comdrv.sv
module lcd_frame_comdrv
  import lcd_frame_pkg::*;
(
  input  logic [1:0]        slot_i,
  input  logic              half_i,
  output logic [2*NCOM-1:0] com_lvl_o
);
  for (genvar i = 0; i < NCOM; i++) begin : g_com
    logic sel;
    lvl_e lvl;
    assign sel = (slot_i == 2'(i));
    always_comb begin
      if (half_i) lvl = sel ? LVL_GND : LVL_TWO;
      else        lvl = sel ? LVL_FULL : LVL_ONE;
    end
    assign com_lvl_o[2*i +: 2] = lvl;
  end
endmodule

// File: rtl/lcd_frame_events.sv
module lcd_frame_events #(
  parameter int WIN = 5,
  parameter int PW = 6
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tick_i,
  input  logic          irq_clr_i,
  input  logic [1:0]    act_mux_i,
  input  logic [PW-1:0] pos_i,
  input  logic [PW-1:0] frame_len_i,
  output logic          fetch_o,
  output logic [1:0]    fetch_slot_o,
  output logic          irq_o
);
  logic [PW-1:0] irq_pos, fetch_first;
  logic          irq_q, set_irq;

  assign irq_pos     = frame_len_i - PW'(WIN);
  assign fetch_first = irq_pos - PW'(act_mux_i) - 1'b1;
  assign fetch_o     = (pos_i >= fetch_first) && (pos_i < irq_pos);
  assign fetch_slot_o = fetch_o ? 2'(pos_i - fetch_first) : 2'd0;

  // set on the tick that moves past the last fetch position
  assign set_irq = tick_i && (pos_i == irq_pos - 1'b1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        irq_q <= 1'b0;
    else if (set_irq)   irq_q <= 1'b1;
    else if (irq_clr_i) irq_q <= 1'b0;
  end

  assign irq_o = irq_q;
endmodule

// File: rtl/lcd_frame_timer.sv
module lcd_frame_timer
  import lcd_frame_pkg::*;
#(
  parameter int SLOT_TICKS   = 4,
  parameter int MARGIN_TICKS = 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic [1:0]        mux_i,
  input  logic              irq_clr_i,
  output logic [2*NCOM-1:0] com_lvl_o,
  output logic              frame_start_o,
  output logic              fetch_o,
  output logic [1:0]        fetch_slot_o,
  output logic              irq_o
);
  localparam int WIN = SLOT_TICKS + MARGIN_TICKS;
  localparam int PW  = $clog2(2 * NCOM * SLOT_TICKS + 1);

  // shortest frame (one common) must still hold the fetch burst before the interrupt
  if (SLOT_TICKS < MARGIN_TICKS + 2) begin : g_bad_cfg
    $error("SLOT_TICKS must exceed MARGIN_TICKS + 1");
  end

  logic [1:0]    act_mux, slot;
  logic          half;
  logic [PW-1:0] pos, frame_len;

  lcd_frame_timebase #(.SLOT_TICKS(SLOT_TICKS), .PW(PW)) u_tb (
    .clk_i, .rst_ni, .tick_i, .mux_i,
    .act_mux_o(act_mux), .slot_o(slot), .half_o(half),
    .pos_o(pos), .frame_len_o(frame_len), .frame_start_o
  );

  lcd_frame_comdrv u_com (
    .slot_i(slot), .half_i(half), .com_lvl_o
  );

  lcd_frame_events #(.WIN(WIN), .PW(PW)) u_ev (
    .clk_i, .rst_ni, .tick_i, .irq_clr_i,
    .act_mux_i(act_mux), .pos_i(pos), .frame_len_i(frame_len),
    .fetch_o, .fetch_slot_o, .irq_o
  );
endmodule

// File: rtl/lcd_frame_timer_chk.sv
module lcd_frame_timer_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       tick_i,
  input logic       irq_clr_i,
  input logic [7:0] com_lvl_o,
  input logic       frame_start_o,
  input logic       fetch_o,
  input logic       irq_o,
  input logic [1:0] act_mux
);
  logic [3:0] extreme;
  for (genvar i = 0; i < 4; i++) begin : g_ext
    assign extreme[i] = (com_lvl_o[2*i +: 2] == 2'd3) || (com_lvl_o[2*i +: 2] == 2'd0);
  end

  AST_ONE_SELECTED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(extreme) == 1) else $error("one selected common");                        // R2
  AST_FS_AFTER_TICK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_start_o |-> $past(tick_i)) else $error("strobe without tick");                 // R3
  AST_FS_COM0: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_start_o |-> com_lvl_o[1:0] == 2'd3) else $error("frame start not on COM0");   // R3
  AST_IRQ_AFTER_FETCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o) |-> !fetch_o && $past(fetch_o)) else $error("irq not after fetch");     // R5
  AST_IRQ_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o && !irq_clr_i |=> irq_o) else $error("irq dropped");                           // R6
  AST_MUX_AT_BOUNDARY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !frame_start_o |-> $stable(act_mux)) else $error("mux changed mid frame");           // R7
endmodule

bind lcd_frame_timer lcd_frame_timer_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick_i), .irq_clr_i(irq_clr_i),
  .com_lvl_o(com_lvl_o), .frame_start_o(frame_start_o), .fetch_o(fetch_o),
  .irq_o(irq_o), .act_mux(act_mux)
);

// File: tb/lcd_frame_timer_test.sv
module lcd_frame_timer_test;
  localparam int S   = 4;
  localparam int M   = 1;
  localparam int WIN = S + M;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       tick_i = 1'b0;
  logic [1:0] mux_i = 2'd3;
  logic       irq_clr_i = 1'b0;
  logic [7:0] com_lvl_o;
  logic       frame_start_o, fetch_o, irq_o;
  logic [1:0] fetch_slot_o;

  int checks = 0, errors = 0;
  int m_pos = 0, m_mux = 3;
  bit m_irq = 0, m_fs = 0, done = 0;

  always #5 clk_i = ~clk_i;

  lcd_frame_timer #(.SLOT_TICKS(S), .MARGIN_TICKS(M)) uut (.*);

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  function automatic int flen_of(int mx);
    return 2 * (mx + 1) * S;
  endfunction

  function automatic logic [7:0] exp_lvl(int pos, int mx);
    int n = mx + 1;
    int slot = (pos / S) % n;
    int half = pos / (S * n);
    logic [7:0] v;
    for (int i = 0; i < 4; i++)
      v[2*i +: 2] = half ? ((i == slot) ? 2'd0 : 2'd2) : ((i == slot) ? 2'd3 : 2'd1);
    return v;
  endfunction

  function automatic int sel_idx(logic [7:0] v);
    for (int i = 0; i < 4; i++)
      if (v[2*i +: 2] == 2'd3 || v[2*i +: 2] == 2'd0) return i;
    return -1;
  endfunction

  task automatic check_all(bit pend);
    int n = m_mux + 1;
    int fl = flen_of(m_mux);
    int ff = fl - WIN - n;
    bit ef = (m_pos >= ff) && (m_pos < fl - WIN);
    chk("R1 selected common", sel_idx(com_lvl_o), (m_pos / S) % n);
    chk(pend ? "R2 R7 levels" : "R2 levels", com_lvl_o, exp_lvl(m_pos, m_mux));
    chk("R3 frame start", frame_start_o, m_fs);
    chk("R4 fetch", fetch_o, ef);
    chk("R4 fetch slot", fetch_slot_o, ef ? m_pos - ff : 0);
    chk("R5 R6 irq", irq_o, m_irq);
  endtask

  task automatic step(bit t, logic [1:0] mx, bit c);
    int fl = flen_of(m_mux);
    int old = m_pos;
    tick_i = t; mux_i = mx; irq_clr_i = c;
    @(posedge clk_i); #1;
    m_fs = 0;
    if (t) begin
      if (old == fl - 1) begin m_pos = 0; m_mux = mx; m_fs = 1; end
      else m_pos = old + 1;
    end
    if (t && old == fl - WIN - 1) m_irq = 1;
    else if (c) m_irq = 0;
    check_all(int'(mx) != m_mux);
    @(negedge clk_i);
  endtask

  initial begin
    int seed = 17;
    void'($urandom(seed));
    #12;
    chk("R8 reset levels", com_lvl_o, 8'h57);
    chk("R8 reset strobe", frame_start_o, 0);
    chk("R8 reset irq", irq_o, 0);
    chk("R8 reset fetch", fetch_o, 0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    // full-rate frames in every duty setting
    for (int d = 3; d >= 0; d--)
      for (int k = 0; k < 80; k++) step(1, 2'(d), 0);
    // clear lands on the set cycle: set must win (R6)
    for (int k = 0; k < 100; k++)
      step(1, 2'd2, (m_pos == flen_of(m_mux) - WIN - 1));
    chk("R6 set wins", irq_o, 1);
    step(0, 2'd2, 1);
    chk("R6 clear", irq_o, 0);
    // random ticks, mid-frame mux changes, random clears
    for (int k = 0; k < 4000; k++) begin
      bit t = ($urandom % 10) < 7;
      logic [1:0] mx = ($urandom % 8 == 0) ? 2'($urandom) : mux_i;
      bit c = ($urandom % 12) == 0;
      step(t, mx, c);
    end
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule